// File: doc/BRIEF.md
# RTC periodic interrupt and square-wave generator

This block is the periodic-event part of a real-time-clock peripheral. A one-cycle strobe from a 32.768 kHz time base drives a programmable divider. A 4-bit rate code in control register A picks the divider period. Each time the divider wraps, it produces a tick. That tick can set the interrupt flags in status register C and raise the interrupt request, and it can also toggle a square-wave output. Each of these two effects has its own enable bit in control register B.

Software reaches the three registers over a byte-wide bus. Reads are combinational and writes are synchronous. A read of register C returns the flags and then clears them, which drops the interrupt request. The divider runs only while it has a consumer, meaning at least one of the two enables is set, and only while the rate code is nonzero.

Top module: `rtc_periodic_top`

## Requirements
- R1: After reset, register A reads 0x26, register B reads 0x02, register C reads 0x00, and irq_o and sqw_o are low.
- R2: The address map is 0 for A, 1 for B, 2 for C and 3 reads 0x00. Writes to A and B store all 8 bits and read back unchanged. Only B bit 6 (periodic interrupt enable) and B bit 3 (square-wave enable) affect behaviour.
- R3: The effective code is the rate code A[3:0], except that codes 1 and 2 become 8 and 9. For an effective code n, a tick occurs on every 2^(n-1)-th time-base strobe.
- R4: When the rate code is 0, or when both B bit 6 and B bit 3 are clear, no tick occurs and the divider is held at zero.
- R5: A tick while B bit 6 is set sets C bits 7 and 6 (C reads 0xC0), and irq_o goes high on the following cycle.
- R6: A tick while B bit 6 is clear leaves register C and irq_o unchanged.
- R7: A tick while B bit 3 is set toggles sqw_o. While B bit 3 is clear, sqw_o is low.
- R8: A read of register C returns its current value and clears it on that clock edge, so irq_o drops on the next cycle. A tick in the same cycle as the read keeps its newly set flags.
- R9: Any write to register A restarts the divider from zero. The first tick then comes after a full period at the new rate.
- R10: Writes to register C are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tb_stb_i | input | 1 | One-cycle strobe at the 32.768 kHz time-base rate |
| cs_i | input | 1 | Register access select |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request, follows C bit 7 |
| sqw_o | output | 1 | Square-wave output |

## Verification
The hardest case to produce is a read of register C that lands on the same edge as a tick. Only then does the set-over-clear ordering become visible. A second hard case is a rate write that arrives partway through a long period. Random traffic pulses the strobe densely while keeping the codes small, so periods stay short and reads often coincide with ticks. Directed sequences measure exact strobe counts after restarts, including the remapped codes and the slowest code.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned RATE_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_A = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_B = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_C = 2'd2;

  localparam int unsigned PIE_BIT  = 6;
  localparam int unsigned SQWE_BIT = 3;

  localparam logic [DATA_W-1:0] A_RST    = 8'h26;
  localparam logic [DATA_W-1:0] B_RST    = 8'h02;
  localparam logic [DATA_W-1:0] FLAG_SET = 8'hC0;

  // codes 1 and 2 alias onto 8 and 9
  function automatic logic [RATE_W-1:0] eff_code(input logic [RATE_W-1:0] c);
    return (c != '0 && c <= RATE_W'(2)) ? c + RATE_W'(7) : c;
  endfunction
endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] reg_a_o,
  output logic [DATA_W-1:0] reg_b_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_a_o <= A_RST;
      reg_b_o <= B_RST;
    end else begin
      if (wr_a_i) reg_a_o <= wdata_i;
      if (wr_b_i) reg_b_o <= wdata_i;
    end
  end
endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
  import rtc_pkg::*;
#(
  parameter int unsigned CODE_W = RATE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int unsigned CNT_W = (1 << CODE_W) - 2;

  logic [CODE_W-1:0] eff;
  logic [CNT_W:0]    period;
  logic [CNT_W-1:0]  last_val;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    eff      = (code_i != '0 && code_i <= CODE_W'(2)) ? code_i + CODE_W'(7) : code_i;
    period   = (CNT_W+1)'(1) << (eff - CODE_W'(1));
    last_val = CNT_W'(period - (CNT_W+1)'(1));
  end

  assign tick_o = stb_i && run_i && !restart_i && (cnt_q == last_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (stb_i)              cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pie_i,
  input  logic              sqwe_i,
  input  logic              rd_c_i,
  output logic [DATA_W-1:0] reg_c_o,
  output logic              sqw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_c_o <= '0;
      sqw_o   <= 1'b0;
    end else begin
      // set wins over read-clear
      reg_c_o <= (rd_c_i ? '0 : reg_c_o) | ((tick_i && pie_i) ? FLAG_SET : '0);
      if (!sqwe_i)     sqw_o <= 1'b0;
      else if (tick_i) sqw_o <= ~sqw_o;
    end
  end
endmodule

// File: rtl/rtc_periodic_top.sv
module rtc_periodic_top
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tb_stb_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sqw_o
);
  logic [DATA_W-1:0] reg_a, reg_b, reg_c;
  logic wr_a, wr_b, rd_c, pie, sqwe, run, tick;
  logic [RATE_W-1:0] rate_code;

  assign wr_a = cs_i && we_i && (addr_i == ADDR_A);
  assign wr_b = cs_i && we_i && (addr_i == ADDR_B);
  assign rd_c = cs_i && !we_i && (addr_i == ADDR_C);

  rtc_ctrl_regs i_regs (
    .clk_i, .rst_ni, .wr_a_i(wr_a), .wr_b_i(wr_b), .wdata_i,
    .reg_a_o(reg_a), .reg_b_o(reg_b)
  );

  assign rate_code = reg_a[RATE_W-1:0];
  assign pie       = reg_b[PIE_BIT];
  assign sqwe      = reg_b[SQWE_BIT];
  assign run       = (rate_code != '0) && (pie || sqwe);

  rtc_rate_div #(.CODE_W(RATE_W)) i_div (
    .clk_i, .rst_ni, .stb_i(tb_stb_i), .run_i(run), .restart_i(wr_a),
    .code_i(rate_code), .tick_o(tick)
  );

  rtc_event_flags i_flags (
    .clk_i, .rst_ni, .tick_i(tick), .pie_i(pie), .sqwe_i(sqwe),
    .rd_c_i(rd_c), .reg_c_o(reg_c), .sqw_o
  );

  assign irq_o = reg_c[7];

  always_comb begin
    unique case (addr_i)
      ADDR_A:  rdata_o = reg_a;
      ADDR_B:  rdata_o = reg_b;
      ADDR_C:  rdata_o = reg_c;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_periodic_chk.sv
module rtc_periodic_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick,
  input logic       pie,
  input logic       sqwe,
  input logic       rd_c,
  input logic [3:0] rate_code,
  input logic       irq_o,
  input logic       sqw_o
);
  assert_idle_no_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_code == 4'd0 || !(pie || sqwe)) |-> !tick);
  assert_tick_raises_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && pie) |=> irq_o);
  assert_irq_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pie && !rd_c) |=> $stable(irq_o));
  assert_sqw_low_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sqwe |=> !sqw_o);
  assert_sqw_toggles_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && sqwe) |=> (sqw_o != $past(sqw_o)));
  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_c && !tick) |=> !irq_o);
endmodule

bind rtc_periodic_top rtc_periodic_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick), .pie(pie), .sqwe(sqwe),
  .rd_c(rd_c), .rate_code(rate_code), .irq_o(irq_o), .sqw_o(sqw_o)
);

// File: tb/test_rtc_periodic_top.sv
module test_rtc_periodic_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tb_stb = 1'b0, cs = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq, sqw;
  int checks = 0, fails = 0;

  // reference state
  logic [7:0] m_a = 8'h26, m_b = 8'h02, m_c = 8'h00;
  int unsigned m_cnt = 0;
  logic m_sqw = 1'b0;

  always #2 clk = ~clk;

  rtc_periodic_top i_rtc_periodic_top (
    .clk_i(clk), .rst_ni(rst_ni), .tb_stb_i(tb_stb), .cs_i(cs), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sqw_o(sqw)
  );

  function automatic int unsigned period_of(input logic [3:0] c);
    int unsigned n = (c == 4'd1 || c == 4'd2) ? c + 7 : c;
    return 1 << (n - 1);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_a;
      2'd1: return m_b;
      2'd2: return m_c;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check, advance model after posedge
  task automatic cyc(input bit c, input bit w, input logic [1:0] a,
                     input logic [7:0] d, input bit s);
    bit run, tick, wa, rc;
    cs = c; we = w; addr = a; wdata = d; tb_stb = s;
    #1;
    chk(irq == m_c[7], "R5 R6 R8 irq", irq, m_c[7]);
    chk(sqw == m_sqw, "R7 sqw", sqw, m_sqw);
    if (c && !w) chk(rdata == exp_rd(a), (a == 2'd2) ? "R8 R10 rdC" : "R2 rd", rdata, exp_rd(a));
    @(posedge clk);
    wa = c && w && a == 2'd0;
    rc = c && !w && a == 2'd2;
    run = (m_a[3:0] != 0) && (m_b[6] || m_b[3]);
    tick = s && run && !wa && (m_cnt == period_of(m_a[3:0]) - 1);
    if (!run || wa) m_cnt = 0;
    else if (s) m_cnt = tick ? 0 : m_cnt + 1;
    m_c = (rc ? 8'h00 : m_c) | ((tick && m_b[6]) ? 8'hC0 : 8'h00);
    if (!m_b[3]) m_sqw = 1'b0; else if (tick) m_sqw = ~m_sqw;
    if (wa) m_a = d;
    if (c && w && a == 2'd1) m_b = d;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1, 1, a, d, 0);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    cs = 1; we = 0; addr = a; tb_stb = 0; #1; v = rdata;
    cyc(1, 0, a, 8'h00, 0);
  endtask

  task automatic strobes_to_irq(output int n);
    n = 0;
    while (!irq && n < 20000) begin cyc(0, 0, 0, 0, 1); n++; end
  endtask

  initial begin
    logic [7:0] v;
    int n, toggles;
    logic prev;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(2'd0, v); chk(v == 8'h26, "R1 A", v, 8'h26);
    rd(2'd1, v); chk(v == 8'h02, "R1 B", v, 8'h02);
    rd(2'd2, v); chk(v == 8'h00, "R1 C", v, 8'h00);
    chk(!irq && !sqw, "R1 outputs", {irq, sqw}, 0);
    rd(2'd3, v); chk(v == 8'h00, "R2 addr3", v, 0);

    // R3 / R5 code 3 period
    wr(2'd1, 8'h40); wr(2'd0, 8'h23);
    strobes_to_irq(n); chk(n == 4, "R3 code3", n, 4);
    rd(2'd2, v); chk(v == 8'hC0, "R5 flags", v, 8'hC0);
    chk(!irq, "R8 irq drop", irq, 0);

    // R3 remap code 1 == code 8
    wr(2'd0, 8'h21); strobes_to_irq(n); chk(n == 128, "R3 code1", n, 128); rd(2'd2, v);
    wr(2'd0, 8'h28); strobes_to_irq(n); chk(n == 128, "R3 code8", n, 128); rd(2'd2, v);
    wr(2'd0, 8'h22); strobes_to_irq(n); chk(n == 256, "R3 code2", n, 256); rd(2'd2, v);
    wr(2'd0, 8'h2F); strobes_to_irq(n); chk(n == 16384, "R3 code15", n, 16384); rd(2'd2, v);

    // R9 restart mid period
    wr(2'd0, 8'h24); repeat (5) cyc(0, 0, 0, 0, 1);
    wr(2'd0, 8'h24); strobes_to_irq(n); chk(n == 8, "R9 restart", n, 8); rd(2'd2, v);

    // R4 code 0 and both enables off
    wr(2'd1, 8'h48); wr(2'd0, 8'h20);
    repeat (200) cyc(0, 0, 0, 0, 1);
    chk(!irq && !sqw, "R4 code0", {irq, sqw}, 0);
    wr(2'd1, 8'hB7); wr(2'd0, 8'h23);
    repeat (200) cyc(0, 0, 0, 0, 1);
    chk(!irq && !sqw, "R4 enables off", {irq, sqw}, 0);

    // R6 / R7 square wave only
    wr(2'd1, 8'h08); toggles = 0; prev = sqw;
    for (int i = 0; i < 40; i++) begin
      cyc(0, 0, 0, 0, 1);
      if (sqw != prev) toggles++;
      prev = sqw;
    end
    chk(toggles == 10, "R7 toggles", toggles, 10);
    rd(2'd2, v); chk(v == 8'h00, "R6 C untouched", v, 0);

    // R10 write C ignored
    wr(2'd2, 8'hFF); rd(2'd2, v); chk(v == 8'h00, "R10 write C", v, 0);

    // R8 read colliding with tick: period 4, tick on 4th strobe
    wr(2'd1, 8'h40); wr(2'd0, 8'h23);
    repeat (3) cyc(0, 0, 0, 0, 1);
    cyc(1, 0, 2'd2, 8'h00, 1);
    chk(irq, "R8 set wins", irq, 1);
    rd(2'd2, v); chk(v == 8'hC0, "R8 kept flags", v, 8'hC0);

    // random traffic, reference model checks every cycle
    for (int i = 0; i < 6000; i++) begin
      int unsigned r = $urandom % 16;
      logic [1:0] a = 2'($urandom % 4);
      logic [7:0] d = 8'($urandom);
      if (a == 2'd0) d[3:0] = 4'($urandom % 6);
      if (r < 2) cyc(1, 1, a, d, $urandom % 2);
      else if (r < 6) cyc(1, 0, a, 0, $urandom % 2);
      else cyc(0, 0, 0, 0, ($urandom % 4) != 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule